// File: doc/BRIEF.md
# Tagged Capability Half-Width Beat Adapter

The adapter sits between a core port that moves 129-bit tagged words (128 data bits plus a validity tag) and a memory data path that is only 64 bits wide. Each beat on the memory path has one user sideband bit. Both sides use valid/ready handshakes.

On the outbound path, one accepted word becomes a burst of exactly two beats. The low half goes first and the high half second. The last flag marks the second beat. The tag is copied onto the user bit of both beats. The adapter takes no new word while a burst is still draining, so a word is never spread across two bursts.

On the inbound path, the adapter collects two consecutive beats and joins them into one tagged word. The first beat received is the low half. The output tag is set only when both received user bits are set. The joined word stays valid and unchanged until the core takes it. While it waits, no further beats are accepted.

Top module: `cap_flit_bridge`

## Requirements
- R1: During reset, `wr_ready` and `mr_ready` are 1, and `mw_valid` and `rd_valid` are 0.
- R2: `wr_ready` is 0 from the cycle after a word is accepted until the second beat of its burst has been taken. It is 1 otherwise.
- R3: The first beat of a burst carries data bits 63:0 with `mw_last`=0. The second beat carries bits 127:64 with `mw_last`=1.
- R4: `mw_user` equals the accepted word's tag on both beats of its burst.
- R5: While `mw_valid` is 1 and `mw_ready` is 0, `mw_data`, `mw_user` and `mw_last` hold their values.
- R6: Each accepted word produces exactly two memory beats. `mw_valid` is 0 in the cycle after the second beat is taken, unless a new word was accepted in between.
- R7: The reassembled `rd_data` is {second beat data, first beat data}. Beats pair up in arrival order.
- R8: `rd_tag` is the AND of the two beats' `mr_user` bits, so a mismatch gives an untagged word.
- R9: `rd_valid` rises only after two beats have arrived. It then stays 1 with stable `rd_data` and `rd_tag` until `rd_ready` is seen.
- R10: `mr_ready` is 0 while a reassembled word is waiting, so no beat is dropped or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Core offers a word to send |
| wr_ready | output | 1 | Adapter can take a word |
| wr_data | input | 128 | Capability data to send |
| wr_tag | input | 1 | Tag of the word to send |
| mw_valid | output | 1 | Outbound beat valid |
| mw_ready | input | 1 | Memory takes the outbound beat |
| mw_data | output | 64 | Outbound beat data |
| mw_user | output | 1 | Outbound beat user bit (tag copy) |
| mw_last | output | 1 | Marks the second beat |
| mr_valid | input | 1 | Inbound beat valid |
| mr_ready | output | 1 | Adapter takes the inbound beat |
| mr_data | input | 64 | Inbound beat data |
| mr_user | input | 1 | Inbound beat user bit |
| rd_valid | output | 1 | Reassembled word valid |
| rd_ready | input | 1 | Core takes the reassembled word |
| rd_data | output | 128 | Reassembled data |
| rd_tag | output | 1 | Reassembled tag |

## Verification
Suppose the outbound beat counter slipped. The next beat would carry the wrong half or the wrong last flag, and a word would show up as one beat or three. The per-cycle model flags this on the very handshake where it happens. If the inbound pairing lost its phase, every later word would have its halves swapped or misaligned, so the first joined word after the fault would be wrong. Long stretches of withheld `rd_ready` and `mw_ready`, together with deliberately unequal user bits, expose faults in the hold and tag logic within a cycle of the stall.

// File: rtl/cap_flit_bridge.sv
module cap_flit_bridge #(
  parameter int BEAT_W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [2*BEAT_W-1:0] wr_data,
  input  logic                wr_tag,
  output logic                mw_valid,
  input  logic                mw_ready,
  output logic [BEAT_W-1:0]   mw_data,
  output logic                mw_user,
  output logic                mw_last,
  input  logic                mr_valid,
  output logic                mr_ready,
  input  logic [BEAT_W-1:0]   mr_data,
  input  logic                mr_user,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [2*BEAT_W-1:0] rd_data,
  output logic                rd_tag
);
  localparam int CAP_W = 2 * BEAT_W;

  // outbound: one held word, split into two beats
  logic [CAP_W-1:0] tx_word;
  logic             tx_tag, tx_busy, tx_hi;

  assign wr_ready = !tx_busy;
  assign mw_valid = tx_busy;
  assign mw_data  = tx_hi ? tx_word[CAP_W-1:BEAT_W] : tx_word[BEAT_W-1:0];
  assign mw_user  = tx_tag;
  assign mw_last  = tx_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_hi   <= 1'b0;
    end else if (wr_valid && wr_ready) begin
      tx_busy <= 1'b1;
      tx_hi   <= 1'b0;
    end else if (mw_valid && mw_ready) begin
      tx_busy <= !tx_hi;
      tx_hi   <= !tx_hi;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_valid && wr_ready) begin
      tx_word <= wr_data;
      tx_tag  <= wr_tag;
    end
  end

  // inbound: pair two beats into one word
  logic [BEAT_W-1:0] rx_lo;
  logic              rx_u0, rx_have_lo, rx_full;
  logic [CAP_W-1:0]  rx_word;
  logic              rx_tag;

  assign mr_ready = !rx_full;
  assign rd_valid = rx_full;
  assign rd_data  = rx_word;
  assign rd_tag   = rx_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_have_lo <= 1'b0;
      rx_full    <= 1'b0;
    end else begin
      if (mr_valid && mr_ready) begin
        rx_have_lo <= !rx_have_lo;
        if (rx_have_lo) rx_full <= 1'b1;
      end else if (rd_valid && rd_ready) begin
        rx_full <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (mr_valid && mr_ready) begin
      if (!rx_have_lo) begin
        rx_lo <= mr_data;
        rx_u0 <= mr_user;
      end else begin
        rx_word <= {mr_data, rx_lo};
        rx_tag  <= rx_u0 & mr_user;
      end
    end
  end

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (mw_valid && !wr_ready && !mw_last));
  p_first_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (mw_data == $past(wr_data[BEAT_W-1:0])));
  p_tag_dup_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && mw_ready && !mw_last) |=> (mw_valid && mw_last && mw_user == $past(mw_user)));
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_data) && $stable(mw_user) && $stable(mw_last)));
  p_two_beats_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && mw_ready && mw_last) |=> !mw_valid);
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data) && $stable(rd_tag)));
  p_rx_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !mr_ready);
endmodule

// File: tb/cap_flit_bridge_tb_top.sv
`timescale 1ns/1ps
module cap_flit_bridge_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic         wr_valid, wr_ready, wr_tag;
  logic [127:0] wr_data;
  logic         mw_valid, mw_ready, mw_user, mw_last;
  logic [63:0]  mw_data;
  logic         mr_valid, mr_ready, mr_user;
  logic [63:0]  mr_data;
  logic         rd_valid, rd_ready, rd_tag;
  logic [127:0] rd_data;

  cap_flit_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data), .wr_tag(wr_tag),
    .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_data(mw_data), .mw_user(mw_user), .mw_last(mw_last),
    .mr_valid(mr_valid), .mr_ready(mr_ready), .mr_data(mr_data), .mr_user(mr_user),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .rd_tag(rd_tag)
  );

  logic [65:0]  beat_q[$];
  logic [128:0] word_q[$];
  logic [63:0]  lo_seen;
  logic         u0_seen;
  bit           second;
  bit           w_fire, r_fire;
  int           errors, checks, mism, words_out;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [128:0] act, input logic [128:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk(wr_ready == (beat_q.size() == 0), "R2", "wr_ready", wr_ready, beat_q.size() == 0);
      chk(mw_valid == (beat_q.size() != 0), "R6", "mw_valid", mw_valid, beat_q.size() != 0);
      if (mw_valid && beat_q.size() != 0) begin
        chk(mw_data == beat_q[0][63:0], "R3/R5", "mw_data", mw_data, beat_q[0][63:0]);
        chk(mw_user == beat_q[0][64], "R4", "mw_user", mw_user, beat_q[0][64]);
        chk(mw_last == beat_q[0][65], "R3", "mw_last", mw_last, beat_q[0][65]);
      end
      chk(mr_ready == (word_q.size() == 0), "R10", "mr_ready", mr_ready, word_q.size() == 0);
      chk(rd_valid == (word_q.size() != 0), "R9", "rd_valid", rd_valid, word_q.size() != 0);
      if (rd_valid && word_q.size() != 0) begin
        chk(rd_data == word_q[0][127:0], "R7", "rd_data", rd_data, word_q[0][127:0]);
        chk(rd_tag == word_q[0][128], "R8", "rd_tag", rd_tag, word_q[0][128]);
      end
      if (mw_valid && mw_ready && beat_q.size() != 0) void'(beat_q.pop_front());
      w_fire = wr_valid && wr_ready;
      if (w_fire) begin
        beat_q.push_back({1'b0, wr_tag, wr_data[63:0]});
        beat_q.push_back({1'b1, wr_tag, wr_data[127:64]});
      end
      if (rd_valid && rd_ready && word_q.size() != 0) begin
        void'(word_q.pop_front());
        words_out++;
      end
      r_fire = mr_valid && mr_ready;
      if (r_fire) begin
        if (!second) begin
          lo_seen = mr_data;
          u0_seen = mr_user;
        end else begin
          word_q.push_back({u0_seen & mr_user, mr_data, lo_seen});
          if (u0_seen != mr_user) mism++;
        end
        second = !second;
      end
    end else begin
      w_fire = 1'b0;
      r_fire = 1'b0;
    end
  end

  initial begin
    #100000;
    checks++;
    errors++;
    $display("FAIL R6 watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wr_valid = 0; wr_data = '0; wr_tag = 0; mw_ready = 0;
    mr_valid = 0; mr_data = '0; mr_user = 0; rd_ready = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(wr_ready == 1'b1, "R1", "wr_ready in reset", wr_ready, 1);
    chk(mr_ready == 1'b1, "R1", "mr_ready in reset", mr_ready, 1);
    chk(mw_valid == 1'b0, "R1", "mw_valid in reset", mw_valid, 0);
    chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      int ph;
      @(posedge clk); #1;
      ph = (cyc < 300) ? 0 : (cyc >= 1500 && cyc < 1700) ? 2 : 1;
      mw_ready = (ph == 0) ? 1'b1 : (ph == 2) ? ($urandom % 4 == 0) : ($urandom % 2 == 1);
      rd_ready = (ph == 0) ? 1'b1 : (ph == 2) ? 1'b0 : ($urandom % 2 == 1);
      if (!wr_valid || w_fire) begin
        wr_valid = (ph == 0) ? 1'b1 : ($urandom % 3 != 0);
        wr_data  = {$urandom, $urandom, $urandom, $urandom};
        wr_tag   = $urandom % 2;
      end
      if (!mr_valid || r_fire) begin
        mr_valid = (ph == 0) ? 1'b1 : ($urandom % 3 != 0);
        mr_data  = {$urandom, $urandom};
        mr_user  = (ph == 0) ? 1'b1 : ($urandom % 4 != 0);
      end
    end
    @(negedge clk);
    chk(mism > 0, "R8", "unequal user pair exercised", mism, 1);
    chk(words_out >= 100, "R7", "reassembled words delivered", words_out, 100);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule